// File: doc/BRIEF.md
# I2C Target Address Matcher

This unit decides whether an I2C target claims a transfer. A bit-level receiver hands it each received byte with a one-cycle strobe, together with START (including repeated START) and STOP indications. After a START the unit examines the first byte, and in 10-bit mode the second byte as well. It raises a match flag, requests an acknowledge for each address byte it accepts, and records the transfer direction and the address that matched. Once the address phase ends, later bytes are ignored until the next START or STOP.

Besides an exact compare with the own address, the unit can match in three other ways. A window match accepts 7-bit addresses strictly above the own address, up to and including a configured upper bound. A 10-bit mode uses a header byte followed by a low-address byte. The reserved address-zero broadcast (general call) can also be matched when it is enabled. The bit-level receiver holds SDA low for acknowledge only when `ack_req` pulses. Otherwise it releases SDA, which gives a NACK.

Top module: `i2c_addr_match`

## Requirements
- R1: The first byte 0x00 after a START matches only when `gc_en` is 1. It then sets `addr_match`, `gc_hit`, `ack_req`, with `rw_dir`=0 and `match_addr`=0. Address 0 never matches through the own-address or window compare. A first byte of 0x01 does not match.
- R2: In 7-bit mode (`ext_en`=0), the first byte holds the address in bits [7:1] and the direction in bit [0], where 1 means read. A match with `own_addr[6:0]` sets `addr_match`, `rw_dir` and `match_addr` (address zero-extended) on the clock edge that samples the strobe.
- R3: In 10-bit mode, the first byte must equal 11110 followed by `own_ext[1:0]` and R/W=0. The second byte must equal `own_addr[7:0]`. Only then is `addr_match` set, with `match_addr` = {`own_ext[1:0]`, `own_addr`}. `own_ext[2]` has no effect in any mode, and `own_ext` has no effect in 7-bit mode.
- R4: With `range_en`=1 in 7-bit mode, a received address A matches when `own_addr[6:0]` < A <= `range_addr`. `match_addr` then reports A.
- R5: With `range_en`=0, an address inside the window produces no match unless it equals the own address.
- R6: While `rst_n` is low and right after reset, all outputs are 0.
- R7: Window matching never applies in 10-bit mode. Neither a second byte nor a first byte that is not a header matches through the window.
- R8: After a completed 10-bit match and without an intervening STOP, a repeated START followed by the header with R/W=1 matches at once, with `rw_dir`=1. After a STOP, that header alone is not acknowledged.
- R9: `stop_det` clears `addr_match`, `gc_hit`, `rw_dir` and `match_addr` on the next edge. It also forgets any completed 10-bit match.
- R10: `ack_req` is high for exactly the one cycle after each accepted address byte. It is low for rejected bytes and for data bytes that follow a match.
- R11: `start_det` clears the match outputs on the next edge, and the next byte is treated as a new first address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_det | input | 1 | START or repeated START seen (one-cycle pulse) |
| stop_det | input | 1 | STOP seen (one-cycle pulse), takes priority over START |
| byte_valid | input | 1 | Strobe: `byte_data` holds a complete received byte |
| byte_data | input | 8 | Received byte, MSB first on the wire |
| gc_en | input | 1 | Enable general-call recognition |
| ext_en | input | 1 | 1 = 10-bit addressing, 0 = 7-bit |
| range_en | input | 1 | Enable window matching (7-bit mode) |
| own_addr | input | 8 | Own address: [6:0] in 7-bit mode, [7:0] low byte in 10-bit mode |
| own_ext | input | 3 | Upper address field: [1:0] are address bits 9:8 in 10-bit mode, [2] unused |
| range_addr | input | 7 | Inclusive upper bound of the match window |
| addr_match | output | 1 | Target is addressed in the current transfer |
| ack_req | output | 1 | One-cycle request to acknowledge the last byte |
| rw_dir | output | 1 | Captured direction, 1 = read |
| gc_hit | output | 1 | Current match is a general call |
| match_addr | output | 10 | Address that produced the match |

## Verification
A sequencer stuck in the wrong phase shows up on `ack_req` one cycle after the next strobe. For example, a data byte gets an acknowledge, or the second 10-bit byte is refused, and every vector walks a full address phase so that lag is always sampled. A stale remembered 10-bit match shows up only after a later repeated START with a read header. The bench therefore pairs the read-header shortcut with the same header after a STOP, and expects opposite results. Wrong compare bounds change `addr_match` and `match_addr` in the cycle after the first byte, so window edges are tested one below, at, and one above each limit.

// File: rtl/i2c_am_pkg.sv
`timescale 1ns/1ps
package i2c_am_pkg;
   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned A7_W     = 7;
   localparam int unsigned A10_W    = 10;
   localparam int unsigned HI_W     = A10_W - BYTE_W;
   localparam int unsigned TAG_W    = BYTE_W - HI_W - 1;
   localparam logic [TAG_W-1:0] HDR10_TAG = 5'b11110;

   typedef enum logic [2:0] {
      AM_IDLE,
      AM_FIRST,
      AM_SECOND,
      AM_HIT,
      AM_MISS
   } am_state_e;
endpackage

// File: rtl/am_cmp7.sv
`timescale 1ns/1ps
module am_cmp7
   import i2c_am_pkg::*;
#(
   parameter int unsigned RANGE_SUPPORT = 1,
   parameter int unsigned GC_SUPPORT    = 1
) (
   input  logic [BYTE_W-1:0] byte_data,
   input  logic [A7_W-1:0]   own7,
   input  logic [A7_W-1:0]   upper7,
   input  logic              gc_en,
   input  logic              range_en,
   output logic              hit7,
   output logic              gc7,
   output logic [A7_W-1:0]   addr7
);
   logic exact;
   logic window;

   assign addr7 = byte_data[BYTE_W-1:1];
   assign exact = (addr7 == own7) && (addr7 != '0);

   generate
      if (RANGE_SUPPORT != 0) begin : g_window
         assign window = range_en && (addr7 > own7) && (addr7 <= upper7);
      end else begin : g_no_window
         logic unused_window;
         assign unused_window = ^{range_en, upper7};
         assign window = 1'b0;
      end

      if (GC_SUPPORT != 0) begin : g_gc
         assign gc7 = gc_en && (byte_data == '0);
      end else begin : g_no_gc
         logic unused_gc;
         assign unused_gc = gc_en;
         assign gc7 = 1'b0;
      end
   endgenerate

   assign hit7 = exact | window;
endmodule

// File: rtl/am_cmp10.sv
`timescale 1ns/1ps
module am_cmp10
   import i2c_am_pkg::*;
(
   input  logic [BYTE_W-1:0] byte_data,
   input  logic [BYTE_W-1:0] own_lo,
   input  logic [HI_W-1:0]   own_hi,
   output logic              hdr_ok,
   output logic              lo_ok
);
   assign hdr_ok = (byte_data[BYTE_W-1:HI_W+1] == HDR10_TAG) &&
                   (byte_data[HI_W:1] == own_hi);
   assign lo_ok  = (byte_data == own_lo);
endmodule

// File: rtl/am_seq.sv
`timescale 1ns/1ps
module am_seq
   import i2c_am_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_det,
   input  logic             stop_det,
   input  logic             byte_valid,
   input  logic             rw_bit,
   input  logic             ext_mode,
   input  logic             hit7,
   input  logic             gc7,
   input  logic [A7_W-1:0]  addr7,
   input  logic             hdr_ok,
   input  logic             lo_ok,
   input  logic [A10_W-1:0] own10,
   output logic             addr_match,
   output logic             ack_req,
   output logic             rw_dir,
   output logic             gc_hit,
   output logic [A10_W-1:0] match_addr
);
   am_state_e        st, st_n;
   logic             ten_known, ten_n;
   logic             match_n, ack_n, rw_n, gc_n;
   logic [A10_W-1:0] ma_n;

   always_comb begin
      st_n    = st;
      ten_n   = ten_known;
      match_n = addr_match;
      ack_n   = 1'b0;
      rw_n    = rw_dir;
      gc_n    = gc_hit;
      ma_n    = match_addr;
      if (stop_det) begin
         st_n = AM_IDLE; ten_n = 1'b0;
         match_n = 1'b0; rw_n = 1'b0; gc_n = 1'b0; ma_n = '0;
      end else if (start_det) begin
         st_n = AM_FIRST;
         match_n = 1'b0; rw_n = 1'b0; gc_n = 1'b0; ma_n = '0;
      end else if (byte_valid) begin
         unique case (st)
            AM_FIRST: begin
               if (gc7) begin
                  st_n = AM_HIT; match_n = 1'b1; ack_n = 1'b1;
                  gc_n = 1'b1; rw_n = 1'b0; ma_n = '0;
               end else if (!ext_mode) begin
                  if (hit7) begin
                     st_n = AM_HIT; match_n = 1'b1; ack_n = 1'b1;
                     rw_n = rw_bit; ma_n = A10_W'(addr7);
                  end else begin
                     st_n = AM_MISS;
                  end
               end else if (hdr_ok && !rw_bit) begin
                  st_n = AM_SECOND; ack_n = 1'b1; rw_n = 1'b0;
               end else if (hdr_ok && ten_known) begin
                  st_n = AM_HIT; match_n = 1'b1; ack_n = 1'b1;
                  rw_n = 1'b1; ma_n = own10;
               end else begin
                  st_n = AM_MISS; ten_n = 1'b0;
               end
            end
            AM_SECOND: begin
               if (lo_ok) begin
                  st_n = AM_HIT; match_n = 1'b1; ack_n = 1'b1;
                  ten_n = 1'b1; ma_n = own10;
               end else begin
                  st_n = AM_MISS; ten_n = 1'b0;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= AM_IDLE;
         ten_known  <= 1'b0;
         addr_match <= 1'b0;
         ack_req    <= 1'b0;
         rw_dir     <= 1'b0;
         gc_hit     <= 1'b0;
         match_addr <= '0;
      end else begin
         st         <= st_n;
         ten_known  <= ten_n;
         addr_match <= match_n;
         ack_req    <= ack_n;
         rw_dir     <= rw_n;
         gc_hit     <= gc_n;
         match_addr <= ma_n;
      end
   end

   p_ack_after_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ack_req |-> $past(byte_valid));
   p_match_needs_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(addr_match) |-> $past(byte_valid));
   p_stop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (!addr_match && !gc_hit && !rw_dir));
   p_start_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (start_det && !stop_det) |=> !addr_match);
   p_dir_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_match && !start_det && !stop_det) |=> (addr_match && $stable(rw_dir)));
endmodule

// File: rtl/i2c_addr_match.sv
`timescale 1ns/1ps
module i2c_addr_match
   import i2c_am_pkg::*;
#(
   parameter int unsigned GC_SUPPORT    = 1,
   parameter int unsigned RANGE_SUPPORT = 1,
   parameter int unsigned EXT_SUPPORT   = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_det,
   input  logic        stop_det,
   input  logic        byte_valid,
   input  logic [7:0]  byte_data,
   input  logic        gc_en,
   input  logic        ext_en,
   input  logic        range_en,
   input  logic [7:0]  own_addr,
   input  logic [2:0]  own_ext,
   input  logic [6:0]  range_addr,
   output logic        addr_match,
   output logic        ack_req,
   output logic        rw_dir,
   output logic        gc_hit,
   output logic [9:0]  match_addr
);
   generate
      if (GC_SUPPORT > 1) begin : g_bad_gc
         $error("GC_SUPPORT must be 0 or 1");
      end
      if (RANGE_SUPPORT > 1) begin : g_bad_range
         $error("RANGE_SUPPORT must be 0 or 1");
      end
      if (EXT_SUPPORT > 1) begin : g_bad_ext
         $error("EXT_SUPPORT must be 0 or 1");
      end
   endgenerate

   logic            hit7, gc7, hdr_ok, lo_ok, ext_mode;
   logic [A7_W-1:0] addr7;
   logic            unused_bits;

   assign unused_bits = ^{own_ext[2], own_addr[7]};

   am_cmp7 #(
      .RANGE_SUPPORT(RANGE_SUPPORT),
      .GC_SUPPORT   (GC_SUPPORT)
   ) i_cmp7 (
      .byte_data(byte_data),
      .own7     (own_addr[A7_W-1:0]),
      .upper7   (range_addr),
      .gc_en    (gc_en),
      .range_en (range_en),
      .hit7     (hit7),
      .gc7      (gc7),
      .addr7    (addr7)
   );

   generate
      if (EXT_SUPPORT != 0) begin : g_ext
         assign ext_mode = ext_en;
         am_cmp10 i_cmp10 (
            .byte_data(byte_data),
            .own_lo   (own_addr),
            .own_hi   (own_ext[HI_W-1:0]),
            .hdr_ok   (hdr_ok),
            .lo_ok    (lo_ok)
         );
      end else begin : g_no_ext
         logic unused_ext;
         assign unused_ext = ext_en;
         assign ext_mode = 1'b0;
         assign hdr_ok   = 1'b0;
         assign lo_ok    = 1'b0;
      end
   endgenerate

   am_seq i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_det (start_det),
      .stop_det  (stop_det),
      .byte_valid(byte_valid),
      .rw_bit    (byte_data[0]),
      .ext_mode  (ext_mode),
      .hit7      (hit7),
      .gc7       (gc7),
      .addr7     (addr7),
      .hdr_ok    (hdr_ok),
      .lo_ok     (lo_ok),
      .own10     ({own_ext[HI_W-1:0], own_addr}),
      .addr_match(addr_match),
      .ack_req   (ack_req),
      .rw_dir    (rw_dir),
      .gc_hit    (gc_hit),
      .match_addr(match_addr)
   );

   p_gc_needs_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gc_hit) |-> $past(gc_en));
   p_gc_is_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
      gc_hit |-> (addr_match && match_addr == '0 && !rw_dir));
   p_reset_quiet_r6: assert property (@(posedge clk)
      !rst_n |-> (!addr_match && !ack_req && !gc_hit));
endmodule

// File: tb/test_i2c_addr_match.sv
`timescale 1ns/1ps
module test_i2c_addr_match;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_det = 1'b0, stop_det = 1'b0, byte_valid = 1'b0;
   logic [7:0] byte_data = '0;
   logic       gc_en = 1'b0, ext_en = 1'b0, range_en = 1'b0;
   logic [7:0] own_addr = '0;
   logic [2:0] own_ext = '0;
   logic [6:0] range_addr = '0;
   logic       addr_match, ack_req, rw_dir, gc_hit;
   logic [9:0] match_addr;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   i2c_addr_match i_i2c_addr_match (
      .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
      .byte_valid(byte_valid), .byte_data(byte_data), .gc_en(gc_en),
      .ext_en(ext_en), .range_en(range_en), .own_addr(own_addr),
      .own_ext(own_ext), .range_addr(range_addr), .addr_match(addr_match),
      .ack_req(ack_req), .rw_dir(rw_dir), .gc_hit(gc_hit),
      .match_addr(match_addr)
   );

   typedef struct packed {
      logic       gc, ext, rng;
      logic [7:0] own;
      logic [2:0] oext;
      logic [6:0] rmax;
      logic       two;
      logic [7:0] b0, b1;
      logic       a0, a1, m, rw, g;
      logic [9:0] ma;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 18;
   // gc ext rng own oext rmax two b0 b1 a0 a1 m rw g ma req
   localparam vec_t VECS [NV] = '{
      '{1'b0,1'b0,1'b0,8'h3A,3'd0,7'h00,1'b0,8'h74,8'h00,1'b1,1'b0,1'b1,1'b0,1'b0,10'h03A,4'd2}, // R2 write
      '{1'b0,1'b0,1'b0,8'h3A,3'd0,7'h00,1'b0,8'h75,8'h00,1'b1,1'b0,1'b1,1'b1,1'b0,10'h03A,4'd2}, // R2 read
      '{1'b0,1'b0,1'b0,8'h3A,3'd0,7'h7F,1'b0,8'h76,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,10'h000,4'd5}, // R5
      '{1'b0,1'b0,1'b1,8'h3A,3'd0,7'h40,1'b0,8'h76,8'h00,1'b1,1'b0,1'b1,1'b0,1'b0,10'h03B,4'd4}, // R4 low edge
      '{1'b0,1'b0,1'b1,8'h3A,3'd0,7'h40,1'b0,8'h81,8'h00,1'b1,1'b0,1'b1,1'b1,1'b0,10'h040,4'd4}, // R4 bound
      '{1'b0,1'b0,1'b1,8'h3A,3'd0,7'h40,1'b0,8'h82,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,10'h000,4'd4}, // R4 above
      '{1'b0,1'b0,1'b1,8'h3A,3'd0,7'h40,1'b0,8'h74,8'h00,1'b1,1'b0,1'b1,1'b0,1'b0,10'h03A,4'd4}, // R4 own
      '{1'b0,1'b0,1'b1,8'h3A,3'd0,7'h40,1'b0,8'h72,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,10'h000,4'd4}, // R4 below
      '{1'b0,1'b0,1'b0,8'h00,3'd0,7'h00,1'b0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,10'h000,4'd1}, // R1 off
      '{1'b1,1'b0,1'b0,8'h3A,3'd0,7'h00,1'b0,8'h00,8'h00,1'b1,1'b0,1'b1,1'b0,1'b1,10'h000,4'd1}, // R1 on
      '{1'b1,1'b0,1'b0,8'h3A,3'd0,7'h00,1'b0,8'h01,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,10'h000,4'd1}, // R1 read
      '{1'b0,1'b1,1'b0,8'h5C,3'd2,7'h00,1'b1,8'hF4,8'h5C,1'b1,1'b1,1'b1,1'b0,1'b0,10'h25C,4'd3}, // R3
      '{1'b0,1'b1,1'b0,8'h5C,3'd2,7'h00,1'b1,8'hF4,8'h5D,1'b1,1'b0,1'b0,1'b0,1'b0,10'h000,4'd3}, // R3 low
      '{1'b0,1'b1,1'b0,8'h5C,3'd2,7'h00,1'b0,8'hF2,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,10'h000,4'd3}, // R3 hdr
      '{1'b0,1'b1,1'b0,8'h5C,3'd6,7'h00,1'b1,8'hF4,8'h5C,1'b1,1'b1,1'b1,1'b0,1'b0,10'h25C,4'd3}, // R3 bit2
      '{1'b0,1'b0,1'b0,8'h3A,3'd7,7'h00,1'b0,8'h74,8'h00,1'b1,1'b0,1'b1,1'b0,1'b0,10'h03A,4'd3}, // R3 7-bit
      '{1'b0,1'b1,1'b1,8'h5C,3'd2,7'h7F,1'b1,8'hF4,8'h5D,1'b1,1'b0,1'b0,1'b0,1'b0,10'h000,4'd7}, // R7
      '{1'b0,1'b1,1'b1,8'h3A,3'd0,7'h7F,1'b0,8'h76,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,10'h000,4'd7}  // R7
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic pulse_start();
      @(negedge clk) start_det = 1'b1;
      @(negedge clk) start_det = 1'b0;
   endtask

   task automatic pulse_stop();
      @(negedge clk) stop_det = 1'b1;
      @(negedge clk) stop_det = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
      @(negedge clk) begin byte_valid = 1'b1; byte_data = b; end
      @(negedge clk) byte_valid = 1'b0;
      check({tag, " ack"}, ack_req, exp_ack);
      @(negedge clk);
      check("R10 ack one cycle", ack_req, 1'b0);
   endtask

   task automatic check_out(input logic m, input logic rw, input logic g,
                            input logic [9:0] ma, input string tag);
      check({tag, " match"}, addr_match, m);
      check({tag, " rw"}, rw_dir, rw);
      check({tag, " gc"}, gc_hit, g);
      check({tag, " addr"}, match_addr, ma);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check_out(1'b0, 1'b0, 1'b0, 10'h0, "R6 in reset");
      check("R6 ack in reset", ack_req, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check_out(1'b0, 1'b0, 1'b0, 10'h0, "R6 after reset");

      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
         pulse_stop();
         gc_en = VECS[i].gc; ext_en = VECS[i].ext; range_en = VECS[i].rng;
         own_addr = VECS[i].own; own_ext = VECS[i].oext; range_addr = VECS[i].rmax;
         pulse_start();
         send_byte(VECS[i].b0, VECS[i].a0, tag);
         if (VECS[i].two) send_byte(VECS[i].b1, VECS[i].a1, tag);
         check_out(VECS[i].m, VECS[i].rw, VECS[i].g, VECS[i].ma, tag);
      end

      // R8 repeated START read shortcut after full 10-bit match
      pulse_stop();
      gc_en = 1'b0; ext_en = 1'b1; range_en = 1'b0;
      own_addr = 8'h5C; own_ext = 3'd2;
      pulse_start();
      send_byte(8'hF4, 1'b1, "R3 hdr");
      send_byte(8'h5C, 1'b1, "R3 low");
      check("R3 match", addr_match, 1'b1);
      pulse_start();
      check("R11 restart clears", addr_match, 1'b0);
      send_byte(8'hF5, 1'b1, "R8 read hdr");
      check_out(1'b1, 1'b1, 1'b0, 10'h25C, "R8 rematch");
      // R10 data byte after match is not acknowledged
      send_byte(8'h5C, 1'b0, "R10 data");
      check("R10 match kept", addr_match, 1'b1);
      // R9 STOP clears and forgets
      pulse_stop();
      check_out(1'b0, 1'b0, 1'b0, 10'h0, "R9 stop");
      pulse_start();
      send_byte(8'hF5, 1'b0, "R8 after stop");
      check("R8 no match after stop", addr_match, 1'b0);

      // R11 new address phase after repeated START in 7-bit mode
      pulse_stop();
      ext_en = 1'b0; own_addr = 8'h3A; own_ext = 3'd0;
      pulse_start();
      send_byte(8'h75, 1'b1, "R2 read");
      check("R2 match", addr_match, 1'b1);
      pulse_start();
      send_byte(8'h10, 1'b0, "R11 other addr");
      check_out(1'b0, 1'b0, 1'b0, 10'h0, "R11 miss");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule